// File: doc/BRIEF.md
# Three-Level Virtual-to-Physical Address Walker

This block turns a 32-bit virtual address into a wider physical address by reading a three-level table tree from memory. The tree starts at a small pointer table of four entries, which is located by a root pointer input. Below it are 4 KB directories and page tables, each holding 512 entries of 64 bits. A directory entry can map a 2 MB region directly, and in that case the walk ends one level early. The walk returns the physical address, a no-execute flag taken from the final entry, and a large-page indication. If the walk cannot finish, it returns a fault code that names the level or reason.

The walker takes one request at a time. It drops its request-ready while it works and gives a one-cycle completion pulse with the result. It reads memory through a valid/ready read-address port. Each read is answered by a single response-valid beat carrying the 64-bit entry. Translation runs only when bit 5 of the mode control input is set. When that bit is clear, a parameter chooses between passing the address through unchanged and reporting a fault.

Top module: `vaddr_walker`

## Requirements
- R1: With mode_ctrl bit 5 clear and the default PASS_THRU=1, a request completes with res_paddr equal to the zero-extended virtual address, res_fault=0, res_nx=0 and res_large=0, and it issues no memory read. The other mode_ctrl bits have no effect.
- R2: With bit 5 set, the first read address is root_ptr with bits 4:0 cleared, plus vaddr[31:30] times 8.
- R3: Later read addresses are the previous entry's bits PA_W-1:12 shifted left by 12, plus 8 times an index. The index is vaddr[29:21] at the directory level and vaddr[20:12] at the page-table level. Every read address is a multiple of 8.
- R4: A 4 KB walk makes exactly three reads and returns res_paddr = {page-table entry bits PA_W-1:12, vaddr[11:0]} with res_large=0.
- R5: A present directory entry with bit 7 set ends the walk after two reads. It returns res_paddr = {entry bits PA_W-1:21, vaddr[20:0]} with res_large=1.
- R6: A present directory entry with bit 7 set and a nonzero value in bits 20:12 ends the walk with res_fault=1 and fault code 4.
- R7: An entry with bit 0 (present) clear stops the walk at once, with no further read. The fault code is 1 for the pointer table, 2 for the directory and 3 for the page table, and res_fault=1 for every nonzero code.
- R8: res_nx equals bit 63 of the entry that ends a successful walk.
- R9: Entry bits 62 down to PA_W, and the flag bits other than 0 and 7, do not change the result.
- R10: req_ready is low from the accepted request until after the done pulse. done lasts exactly one cycle, and a walk issues at most three reads.
- R11: A read request that is not accepted keeps mem_rd_valid high and mem_rd_addr unchanged until mem_rd_ready is seen, and the result is unaffected by such stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted on valid&ready |
| req_vaddr | input | 32 | Virtual address to translate |
| mode_ctrl | input | 32 | Mode control word; bit 5 enables translation |
| root_ptr | input | PA_W | Base of the four-entry pointer table (bits 4:0 ignored) |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | PA_W | Byte address of the 64-bit entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Entry data |
| done | output | 1 | One-cycle completion pulse |
| res_paddr | output | PA_W | Physical address |
| res_nx | output | 1 | No-execute flag of the final entry |
| res_large | output | 1 | 2 MB mapping used |
| res_fault | output | 1 | Walk failed |
| res_fault_code | output | 3 | 0 none, 1..3 not-present level, 4 reserved bits, 5 translation off with PASS_THRU=0 |

## Verification
The assertions assume that memory answers only reads it has accepted, with one response per read, and that no response arrives outside a walk. The bench memory model enforces this. It latches a handshake at the falling edge and returns data on the following cycle, and it never produces a spontaneous beat. The assertions also assume that requests arrive only while req_ready is high, so the bench waits for the completion pulse before driving the next request. Stall behaviour comes from a mode in which memory ready alternates every cycle.

// File: rtl/walk_pkg.sv
package walk_pkg;

  localparam int VA_W    = 32;
  localparam int ENT_W   = 64;
  localparam int FULL_PA = 52;
  localparam int EN_BIT  = 5;
  localparam int IDX_W   = 9;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_FIN} walk_st_e;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_TOP_NP = 3'd1,
    FLT_DIR_NP = 3'd2,
    FLT_TBL_NP = 3'd3,
    FLT_RSVD   = 3'd4,
    FLT_OFF    = 3'd5
  } walk_flt_e;

  // byte address of entry number idx inside a table at base
  function automatic logic [FULL_PA-1:0] ent_addr(input logic [FULL_PA-1:0] base,
                                                  input logic [IDX_W-1:0] idx);
    return base + {{(FULL_PA-IDX_W-3){1'b0}}, idx, 3'b000};
  endfunction

  function automatic logic [FULL_PA-1:0] pa_small(input logic [ENT_W-1:0] e,
                                                  input logic [11:0] off);
    return {e[51:12], off};
  endfunction

  function automatic logic [FULL_PA-1:0] pa_large(input logic [ENT_W-1:0] e,
                                                  input logic [20:0] off);
    return {e[51:21], off};
  endfunction

endpackage

// File: rtl/walk_idx_sel.sv
module walk_idx_sel
  import walk_pkg::*;
(
  input  logic [VA_W-1:0]  va,
  input  logic [1:0]       lvl,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    case (lvl)
      2'd0:    idx = {7'd0, va[31:30]};
      2'd1:    idx = va[29:21];
      default: idx = va[20:12];
    endcase
  end
endmodule

// File: rtl/walk_entry_dec.sv
module walk_entry_dec
  import walk_pkg::*;
#(
  parameter int PA_W = 36
) (
  input  logic [ENT_W-1:0] ent,
  output logic             present,
  output logic             big,
  output logic             nx,
  output logic             rsvd_nz,
  output logic [PA_W-1:0]  next_base
);
  logic unused_sw;

  assign present   = ent[0];
  assign big       = ent[7];
  assign nx        = ent[63];
  assign rsvd_nz   = |ent[20:12];
  assign next_base = PA_W'({ent[51:12], 12'h000});
  assign unused_sw = ^{ent[62:52], ent[11:8], ent[6:1]};
endmodule

// File: rtl/vaddr_walker.sv
module vaddr_walker
  import walk_pkg::*;
#(
  parameter int PA_W      = 36,
  parameter bit PASS_THRU = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_vaddr,
  input  logic [31:0]      mode_ctrl,
  input  logic [PA_W-1:0]  root_ptr,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [63:0]      mem_rsp_data,
  output logic             done,
  output logic [PA_W-1:0]  res_paddr,
  output logic             res_nx,
  output logic             res_large,
  output logic             res_fault,
  output logic [2:0]       res_fault_code
);
  localparam logic [PA_W-1:0] ROOT_MASK = ~PA_W'(31);

  walk_st_e        st_q;
  logic [1:0]      lvl_q;
  logic [PA_W-1:0] base_q;
  logic [31:0]     va_q;

  logic [IDX_W-1:0]   idx;
  logic [FULL_PA-1:0] ea_full;
  logic               e_present, e_big, e_nx, e_rsvd;
  logic [PA_W-1:0]    e_base;
  logic               unused_mode;

  // named events for the checker
  logic evt_accept, evt_rd_fire, evt_rsp;
  logic trans_on;

  walk_idx_sel u_idx (.va(va_q), .lvl(lvl_q), .idx(idx));

  walk_entry_dec #(.PA_W(PA_W)) u_dec (
    .ent(mem_rsp_data), .present(e_present), .big(e_big),
    .nx(e_nx), .rsvd_nz(e_rsvd), .next_base(e_base)
  );

  assign trans_on     = mode_ctrl[EN_BIT];
  assign unused_mode  = ^mode_ctrl;
  assign req_ready    = (st_q == ST_IDLE);
  assign mem_rd_valid = (st_q == ST_ISSUE);
  assign done         = (st_q == ST_FIN);
  assign ea_full      = ent_addr(FULL_PA'(base_q), idx);
  assign mem_rd_addr  = PA_W'(ea_full);
  assign evt_accept   = req_valid && req_ready;
  assign evt_rd_fire  = mem_rd_valid && mem_rd_ready;
  assign evt_rsp      = (st_q == ST_WAIT) && mem_rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q           <= ST_IDLE;
      lvl_q          <= 2'd0;
      base_q         <= '0;
      va_q           <= '0;
      res_paddr      <= '0;
      res_nx         <= 1'b0;
      res_large      <= 1'b0;
      res_fault      <= 1'b0;
      res_fault_code <= FLT_NONE;
    end else begin
      case (st_q)
        ST_IDLE: if (evt_accept) begin
          va_q      <= req_vaddr;
          res_nx    <= 1'b0;
          res_large <= 1'b0;
          if (trans_on) begin
            lvl_q  <= 2'd0;
            base_q <= root_ptr & ROOT_MASK;
            st_q   <= ST_ISSUE;
          end else begin
            res_paddr      <= PASS_THRU ? PA_W'(req_vaddr) : '0;
            res_fault      <= !PASS_THRU;
            res_fault_code <= PASS_THRU ? FLT_NONE : FLT_OFF;
            st_q           <= ST_FIN;
          end
        end
        ST_ISSUE: if (evt_rd_fire) st_q <= ST_WAIT;
        ST_WAIT: if (evt_rsp) begin
          if (!e_present) begin
            res_fault      <= 1'b1;
            res_fault_code <= 3'(lvl_q) + 3'd1;
            res_paddr      <= '0;
            st_q           <= ST_FIN;
          end else if (lvl_q == 2'd1 && e_big) begin
            st_q <= ST_FIN;
            if (e_rsvd) begin
              res_fault      <= 1'b1;
              res_fault_code <= FLT_RSVD;
              res_paddr      <= '0;
            end else begin
              res_fault      <= 1'b0;
              res_fault_code <= FLT_NONE;
              res_paddr      <= PA_W'(pa_large(mem_rsp_data, va_q[20:0]));
              res_nx         <= e_nx;
              res_large      <= 1'b1;
            end
          end else if (lvl_q == 2'd2) begin
            res_fault      <= 1'b0;
            res_fault_code <= FLT_NONE;
            res_paddr      <= PA_W'(pa_small(mem_rsp_data, va_q[11:0]));
            res_nx         <= e_nx;
            st_q           <= ST_FIN;
          end else begin
            base_q <= e_base;
            lvl_q  <= lvl_q + 2'd1;
            st_q   <= ST_ISSUE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/walk_chk.sv
module walk_chk #(
  parameter int PA_W = 36
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic [31:0]     req_vaddr,
  input logic            mem_rd_valid,
  input logic            mem_rd_ready,
  input logic [PA_W-1:0] mem_rd_addr,
  input logic            done,
  input logic [PA_W-1:0] res_paddr,
  input logic            res_large,
  input logic            res_fault,
  input logic [2:0]      res_fault_code,
  input logic            evt_accept,
  input logic            evt_rd_fire
);
  logic [31:0] va_cap;
  logic [2:0]  rd_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_cap <= '0;
      rd_cnt <= '0;
    end else if (evt_accept) begin
      va_cap <= req_vaddr;
      rd_cnt <= '0;
    end else if (evt_rd_fire) begin
      rd_cnt <= rd_cnt + 3'd1;
    end
  end

  AST_RD_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !req_ready);                                   // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                // R10
  AST_READ_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rd_fire |-> rd_cnt < 3'd3);                                 // R10
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R11
  AST_RD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> (mem_rd_addr[2:0] == 3'd0));                   // R3
  AST_SMALL_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !res_fault) |-> (res_paddr[11:0] == va_cap[11:0]));    // R4
  AST_LARGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_large) |-> (res_paddr[20:0] == va_cap[20:0]));     // R5
  AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (res_fault == (res_fault_code != 3'd0)));              // R7
  AST_FAULT_NOT_LARGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_fault) |-> !res_large);                            // R6
endmodule

bind vaddr_walker walk_chk #(.PA_W(PA_W)) u_walk_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_vaddr(req_vaddr),
  .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
  .mem_rd_addr(mem_rd_addr), .done(done), .res_paddr(res_paddr),
  .res_large(res_large), .res_fault(res_fault),
  .res_fault_code(res_fault_code), .evt_accept(evt_accept),
  .evt_rd_fire(evt_rd_fire)
);

// File: tb/vaddr_walker_test.sv
`timescale 1ns/1ps
module vaddr_walker_test;
  localparam int PW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [31:0]   req_vaddr = '0;
  logic [31:0]   mode_ctrl = 32'h20;
  logic [PW-1:0] root_ptr = 36'h0_0000_1020;
  logic          mem_rd_valid;
  logic          mem_rd_ready = 1'b1;
  logic [PW-1:0] mem_rd_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [63:0]   mem_rsp_data = '0;
  logic          done;
  logic [PW-1:0] res_paddr;
  logic          res_nx, res_large, res_fault;
  logic [2:0]    res_fault_code;

  int n_chk = 0;
  int n_err = 0;
  int n_rd  = 0;
  bit stall = 0;
  logic [PW-1:0] rd_log [4];
  logic [63:0] mem [logic [PW-1:0]];

  // captured results
  logic [PW-1:0] c_pa;
  logic c_nx, c_large, c_fault;
  logic [2:0] c_code;

  always #2.5 clk = ~clk;

  vaddr_walker #(.PA_W(PW), .PASS_THRU(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .mode_ctrl(mode_ctrl), .root_ptr(root_ptr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .res_paddr(res_paddr),
    .res_nx(res_nx), .res_large(res_large), .res_fault(res_fault),
    .res_fault_code(res_fault_code)
  );

  // memory model: handshake seen at the falling edge, answered next cycle
  initial begin
    forever begin
      logic hs;
      logic [PW-1:0] a;
      @(negedge clk);
      hs = mem_rd_valid && mem_rd_ready;
      a  = mem_rd_addr;
      if (hs) begin
        if (n_rd < 4) rd_log[n_rd] = a;
        n_rd = n_rd + 1;
      end
      @(posedge clk);
      mem_rsp_valid <= hs;
      mem_rsp_data  <= (hs && mem.exists(a)) ? mem[a] : 64'd0;
      mem_rd_ready  <= stall ? ~mem_rd_ready : 1'b1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] tbase(input logic [PW-1:0] r);
    return {r[PW-1:5], 5'd0};
  endfunction

  function automatic logic [PW-1:0] slot(input logic [PW-1:0] b, input int i);
    return b + PW'(i * 8);
  endfunction

  // one translation; checks ready stays low and done is a single pulse
  task automatic xlat(input logic [31:0] va);
    int guard = 0;
    bit busy_bad = 0;
    n_rd = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && guard < 200) begin
      if (req_ready) busy_bad = 1;
      @(negedge clk);
      guard++;
    end
    if (req_ready) busy_bad = 1;
    c_pa = res_paddr; c_nx = res_nx; c_large = res_large;
    c_fault = res_fault; c_code = res_fault_code;
    chk("R10 done seen", 64'(done), 64'd1);
    chk("R10 ready low while busy", 64'(busy_bad), 64'd0);
    @(negedge clk);
    chk("R10 done single cycle", 64'(done), 64'd0);
  endtask

  task automatic t_reset;
    chk("R10 reset ready", 64'(req_ready), 64'd1);
    chk("R10 reset done", 64'(done), 64'd0);
    chk("R11 reset no read", 64'(mem_rd_valid), 64'd0);
  endtask

  task automatic t_off(input logic [31:0] va);
    mode_ctrl = 32'hFFFF_FFDF;
    xlat(va);
    chk("R1 pass-through pa", 64'(c_pa), 64'(va));
    chk("R1 no fault", {61'd0, c_fault, c_nx, c_large}, 64'd0);
    chk("R1 no reads", 64'(n_rd), 64'd0);
    mode_ctrl = 32'h20;
  endtask

  task automatic t_small(input logic [31:0] va, input logic [PW-1:0] pd,
                         input logic [PW-1:0] pt, input logic [PW-1:0] pg,
                         input bit nx, input logic [63:0] junk, input string tag);
    logic [PW-1:0] a0, a1, a2;
    mem.delete();
    a0 = slot(tbase(root_ptr), int'(va[31:30]));
    a1 = slot(pd, int'(va[29:21]));
    a2 = slot(pt, int'(va[20:12]));
    mem[a0] = 64'(pd) | 64'h1 | junk;
    mem[a1] = 64'(pt) | 64'h3 | junk;
    mem[a2] = 64'(pg) | 64'h61 | junk | {nx, 63'd0};
    xlat(va);
    chk({"R4 small pa ", tag}, 64'(c_pa), 64'({pg[PW-1:12], va[11:0]}));
    chk({"R4 three reads ", tag}, 64'(n_rd), 64'd3);
    chk({"R4 not large ", tag}, {62'd0, c_large, c_fault}, 64'd0);
    chk({"R8 nx ", tag}, 64'(c_nx), 64'(nx));
    chk({"R2 top read addr ", tag}, 64'(rd_log[0]), 64'(a0));
    chk({"R3 dir read addr ", tag}, 64'(rd_log[1]), 64'(a1));
    chk({"R3 table read addr ", tag}, 64'(rd_log[2]), 64'(a2));
  endtask

  task automatic t_large(input logic [31:0] va, input logic [PW-1:0] pd,
                         input logic [PW-1:0] pg, input bit nx);
    logic [PW-1:0] a0, a1;
    mem.delete();
    a0 = slot(tbase(root_ptr), int'(va[31:30]));
    a1 = slot(pd, int'(va[29:21]));
    mem[a0] = 64'(pd) | 64'h1;
    mem[a1] = 64'(pg) | 64'h81 | {nx, 63'd0};
    xlat(va);
    chk("R5 large pa", 64'(c_pa), 64'({pg[PW-1:21], va[20:0]}));
    chk("R5 large flag", 64'(c_large), 64'd1);
    chk("R5 two reads", 64'(n_rd), 64'd2);
    chk("R8 large nx", 64'(c_nx), 64'(nx));
    chk("R5 no fault", 64'(c_fault), 64'd0);
  endtask

  task automatic t_rsvd(input logic [31:0] va);
    logic [PW-1:0] pd = 36'h0_0002_0000;
    mem.delete();
    mem[slot(tbase(root_ptr), int'(va[31:30]))] = 64'(pd) | 64'h1;
    mem[slot(pd, int'(va[29:21]))] = 64'h5_5540_0081 | 64'h2000;
    xlat(va);
    chk("R6 reserved fault", 64'(c_fault), 64'd1);
    chk("R6 reserved code", 64'(c_code), 64'd4);
    chk("R6 two reads", 64'(n_rd), 64'd2);
  endtask

  task automatic t_absent(input int lvl, input logic [31:0] va);
    logic [PW-1:0] pd = 36'h0_0003_0000;
    logic [PW-1:0] pt = 36'h0_0004_0000;
    mem.delete();
    mem[slot(tbase(root_ptr), int'(va[31:30]))] = (lvl == 1) ? 64'h0 : (64'(pd) | 64'h1);
    mem[slot(pd, int'(va[29:21]))] = (lvl == 2) ? 64'h5_5540_0080 : (64'(pt) | 64'h1);
    mem[slot(pt, int'(va[20:12]))] = 64'h9_ABCD_E000;
    xlat(va);
    chk($sformatf("R7 absent fault L%0d", lvl), 64'(c_fault), 64'd1);
    chk($sformatf("R7 absent code L%0d", lvl), 64'(c_code), 64'(lvl));
    chk($sformatf("R7 stop reads L%0d", lvl), 64'(n_rd), 64'(lvl));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_off(32'hDEAD_BEEF);
    t_off(32'h0000_0FFF);
    // R9: junk in bits 62:36 and unused flag bits ignored
    t_small(32'h4060_3ABC, 36'h0_0002_0000, 36'h3_0004_0000, 36'h9_ABCD_E000,
            1'b1, 64'h7FF0_0100_0000_0000, "R9 junk");
    t_small(32'hFFFF_F001, 36'h0_0005_0000, 36'h1_0000_7000, 36'h0_1234_5000,
            1'b0, 64'd0, "clean");
    root_ptr = 36'h0_0000_1027;  // low bits ignored (R2)
    t_small(32'h0020_1777, 36'h0_0006_0000, 36'h0_0007_0000, 36'hF_FFFF_F000,
            1'b0, 64'd0, "R2 root low bits");
    root_ptr = 36'h0_0000_1020;
    t_large(32'hC1A5_4321, 36'h0_0002_0000, 36'h5_5540_0000, 1'b1);
    t_large(32'h0000_0000, 36'h0_0008_0000, 36'hF_FFE0_0000, 1'b0);
    t_rsvd(32'h8123_4567);
    t_absent(1, 32'h4060_3ABC);
    t_absent(2, 32'h4060_3ABC);
    t_absent(3, 32'h4060_3ABC);
    stall = 1;  // R11: memory ready toggles every cycle
    t_small(32'h9876_5432, 36'h0_0009_0000, 36'h0_000A_0000, 36'h2_2222_2000,
            1'b1, 64'd0, "R11 stall");
    t_large(32'h7FFF_FFFF, 36'h0_000B_0000, 36'h1_0020_0000, 1'b0);
    stall = 0;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired R10 actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule